// File: doc/BRIEF.md
# Time-Slot Interchanger with Connection Memory

The block moves 8-bit samples between serial streams. Every input stream carries a frame of time slots, one byte per slot, most significant bit first. Each incoming byte is stored in a two-bank data memory. One bank collects the current frame while the other still holds the previous frame, and the banks change roles at every frame boundary. For every output stream and output slot, a connection memory holds one entry. The entry names the source stream and slot, picks how the byte is delayed or whether a fixed byte is sent, and sets whether the output is driven in that slot. A host loads the entries through a single write strobe.

Both converters have a bypass. With the input bypass set, the input bytes are taken whole from a parallel bus instead of being shifted in. With the output bypass set, each output byte is presented whole on a parallel bus instead of being shifted out. Each entry also carries a control-strobe bit, which is sent out directly from the connection memory one slot ahead of the byte it belongs to.

The design runs at one bit per clock, with 8 clocks per slot and 64 slots per frame by default. After the reset is released, the frame counter starts at bit 0 of slot 0 of frame 0. Output slot s of a frame is sent during input slot s+1, so the latency is one slot.

Top module: `tsi_switch`

## Requirements
- R1: While the block is in reset, and in the first cycle after it, the outputs are idle: every `out_en` bit is 0, every `out_ser` bit is 1, every `ctl_strobe` bit is 0 and `out_par` is all ones. The reset clears every connection entry.
- R2: Serial input bit b (0..7) of slot s is bit 7-b of that slot's byte. Output slot s of frame f is sent during input slot s+1, counted from slot 0 of frame f and wrapping into the next frame. Its bits go out MSB first, and `out_en` stays constant for the whole slot.
- R3: Entry fields, for the default widths: bits [7:6] hold the source stream, bits [5:0] the source slot, bit 8 the enable, bit 9 the minimum-delay select, bit 10 pattern mode and bit 11 the control strobe. An entry is written at address {output stream, output slot}. If bits 9 and 10 are both 0 (constant delay), output slot s of frame f carries the byte that entered at the source stream and slot in frame f-1.
- R4: If bit 9 is 1 and bit 10 is 0 (minimum delay), the byte comes from frame f when the source slot is less than s. Otherwise it comes from frame f-1.
- R5: If bit 10 is 1 (pattern mode), the output byte is bits [7:0] of the entry, whatever the data memory holds.
- R6: If bit 8 of an entry is 0, `out_en` is 0 for that output slot, `out_ser` stays 1 and `out_par` stays all ones.
- R7: During input slot t, `ctl_strobe[o]` equals bit 11 of the entry at address {o, t}. It therefore leads the byte of that entry by one slot.
- R8: While `sp_bypass` is 1, the byte of each input slot is taken from `in_par` at the last bit of the slot, and `in_ser` is ignored.
- R9: While `ps_bypass` is 1, `out_ser` is all ones and `out_par` carries the byte of the current output slot. While `ps_bypass` is 0, `out_par` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sp_bypass | input | 1 | Take input bytes from `in_par` |
| ps_bypass | input | 1 | Present output bytes on `out_par` |
| in_ser | input | 4 | Serial input streams |
| in_par | input | 32 | Parallel input bytes, stream i in bits [8i+7:8i] |
| cfg_we | input | 1 | Connection entry write strobe |
| cfg_addr | input | 8 | Entry address {output stream, output slot} |
| cfg_data | input | 12 | Entry value |
| out_ser | output | 4 | Serial output streams |
| out_en | output | 4 | Per-slot drive enable |
| out_par | output | 32 | Parallel output bytes, stream i in bits [8i+7:8i] |
| ctl_strobe | output | 4 | Control-strobe stream read straight from connection memory |

## Verification
An input byte is written at the clock edge that ends its slot. The byte for output slot s is loaded at the edge that ends input slot s, and its bit j is on `out_ser` during cycle 8(s+1)+j of the frame. The control strobe for slot t already shows during input slot t. When the driver finishes each input slot, it pushes the expected bytes and enables of all outputs for that slot. The monitor pops them exactly at bit 0 of the following slot and compares each bit in its own cycle. The strobe and parallel outputs are compared in the middle of the slot. Every sample is taken at the falling clock edge, and new inputs are driven one time step later.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int BYTE_W = 8;
  localparam int CTL_W  = 4;

  // control field placed above the source field of an entry
  typedef struct packed {
    logic strobe;
    logic pattern;
    logic min_dly;
    logic enable;
  } tsi_ctl_t;
endpackage

// File: rtl/tsi_timing.sv
module tsi_timing #(
  parameter int SLOT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [2:0]        bit_idx,
  output logic [SLOT_W-1:0] slot_idx,
  output logic              wr_bank,
  output logic              slot_last
);
  logic              frame_last;
  logic [2:0]        bit_nx;
  logic [SLOT_W-1:0] slot_nx;
  logic              bank_nx;

  always_comb begin
    slot_last  = (bit_idx == 3'd7);
    frame_last = slot_last && (slot_idx == {SLOT_W{1'b1}});
    bit_nx     = bit_idx + 3'd1;
    slot_nx    = slot_last ? slot_idx + {{(SLOT_W-1){1'b0}}, 1'b1} : slot_idx;
    bank_nx    = frame_last ? ~wr_bank : wr_bank;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_idx  <= '0;
      slot_idx <= '0;
      wr_bank  <= 1'b0;
    end else begin
      bit_idx  <= bit_nx;
      slot_idx <= slot_nx;
      wr_bank  <= bank_nx;
    end
  end
endmodule

// File: rtl/tsi_rx.sv
module tsi_rx #(
  parameter int NSTR   = 4,
  parameter int BYTE_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sp_bypass,
  input  logic [NSTR-1:0]        ser_in,
  input  logic [NSTR*BYTE_W-1:0] par_in,
  output logic [NSTR*BYTE_W-1:0] byte_out
);
  for (genvar i = 0; i < NSTR; i++) begin : g_lane
    logic [BYTE_W-2:0] sr_q;
    logic [BYTE_W-2:0] sr_nx;
    logic [BYTE_W-1:0] full;

    always_comb begin
      full  = {sr_q, ser_in[i]};
      sr_nx = full[BYTE_W-2:0];
      byte_out[i*BYTE_W +: BYTE_W] = sp_bypass ? par_in[i*BYTE_W +: BYTE_W] : full;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr_q <= '0;
      else        sr_q <= sr_nx;
    end
  end
endmodule

// File: rtl/tsi_dmem.sv
module tsi_dmem #(
  parameter int STRM_W = 2,
  parameter int SLOT_W = 6,
  parameter int BYTE_W = 8
) (
  input  logic                          clk,
  input  logic                          we,
  input  logic                          wr_bank,
  input  logic [SLOT_W-1:0]             wr_slot,
  input  logic [(1<<STRM_W)*BYTE_W-1:0] wr_bytes,
  input  logic [(1<<STRM_W)-1:0]        rd_bank,
  input  logic [(1<<STRM_W)*(STRM_W+SLOT_W)-1:0] rd_addr,
  output logic [(1<<STRM_W)*BYTE_W-1:0] rd_data
);
  localparam int NSTR  = 1 << STRM_W;
  localparam int SRC_W = STRM_W + SLOT_W;
  localparam int DEPTH = 2 * NSTR * (1 << SLOT_W);

  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int s = 0; s < NSTR; s++) begin
        mem[{wr_bank, STRM_W'(s), wr_slot}] <= wr_bytes[s*BYTE_W +: BYTE_W];
      end
    end
  end

  for (genvar p = 0; p < NSTR; p++) begin : g_rd
    assign rd_data[p*BYTE_W +: BYTE_W] = mem[{rd_bank[p], rd_addr[p*SRC_W +: SRC_W]}];
  end
endmodule

// File: rtl/tsi_cmem.sv
module tsi_cmem #(
  parameter int STRM_W = 2,
  parameter int SLOT_W = 6,
  parameter int ENT_W  = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [STRM_W+SLOT_W-1:0]      waddr,
  input  logic [ENT_W-1:0]              wdata,
  input  logic [SLOT_W-1:0]             rd_slot,
  output logic [(1<<STRM_W)*ENT_W-1:0]  rd_ent
);
  localparam int NSTR  = 1 << STRM_W;
  localparam int DEPTH = NSTR * (1 << SLOT_W);

  logic [ENT_W-1:0] ent_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else if (we) begin
      ent_q[waddr] <= wdata;
    end
  end

  // all outputs read the entry for the current slot in parallel
  for (genvar o = 0; o < NSTR; o++) begin : g_rd
    assign rd_ent[o*ENT_W +: ENT_W] = ent_q[{STRM_W'(o), rd_slot}];
  end
endmodule

// File: rtl/tsi_tx.sv
module tsi_tx
  import tsi_pkg::*;
#(
  parameter int STRM_W = 2,
  parameter int SLOT_W = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic                       ps_bypass,
  input  logic [STRM_W+SLOT_W+CTL_W-1:0] ent,
  input  logic [SLOT_W-1:0]          cur_slot,
  input  logic                       wr_bank,
  input  logic [BYTE_W-1:0]          mem_byte,
  output logic                       rd_bank,
  output logic [STRM_W+SLOT_W-1:0]   rd_addr,
  output logic                       ser_out,
  output logic                       drv_en,
  output logic [BYTE_W-1:0]          par_out
);
  localparam int SRC_W = STRM_W + SLOT_W;
  localparam int ENT_W = SRC_W + CTL_W;

  tsi_ctl_t          ctl;
  logic [SRC_W-1:0]  src;
  logic [SLOT_W-1:0] src_slot;
  logic [BYTE_W-1:0] pick;
  logic [BYTE_W-1:0] sh_q, sh_nx, hold_q, hold_nx;
  logic              en_q, en_nx;

  always_comb begin
    ctl      = tsi_ctl_t'(ent[ENT_W-1 -: CTL_W]);
    src      = ent[SRC_W-1:0];
    src_slot = src[SLOT_W-1:0];
    // the slot being written at this edge is not yet visible: use previous frame
    rd_bank  = (ctl.min_dly && (src_slot < cur_slot)) ? wr_bank : ~wr_bank;
    rd_addr  = src;
    pick     = ctl.pattern ? src[BYTE_W-1:0] : mem_byte;
  end

  always_comb begin
    sh_nx   = {sh_q[BYTE_W-2:0], 1'b1};
    hold_nx = hold_q;
    en_nx   = en_q;
    if (load) begin
      sh_nx   = pick;
      hold_nx = pick;
      en_nx   = ctl.enable;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      hold_q <= '1;
      en_q   <= 1'b0;
    end else begin
      sh_q   <= sh_nx;
      hold_q <= hold_nx;
      en_q   <= en_nx;
    end
  end

  always_comb begin
    drv_en  = en_q;
    ser_out = (en_q && !ps_bypass) ? sh_q[BYTE_W-1] : 1'b1;
    par_out = (en_q && ps_bypass) ? hold_q : '1;
  end
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
#(
  parameter int STRM_W = 2,
  parameter int SLOT_W = 6
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 sp_bypass,
  input  logic                                 ps_bypass,
  input  logic [(1<<STRM_W)-1:0]               in_ser,
  input  logic [(1<<STRM_W)*BYTE_W-1:0]        in_par,
  input  logic                                 cfg_we,
  input  logic [STRM_W+SLOT_W-1:0]             cfg_addr,
  input  logic [STRM_W+SLOT_W+CTL_W-1:0]       cfg_data,
  output logic [(1<<STRM_W)-1:0]               out_ser,
  output logic [(1<<STRM_W)-1:0]               out_en,
  output logic [(1<<STRM_W)*BYTE_W-1:0]        out_par,
  output logic [(1<<STRM_W)-1:0]               ctl_strobe
);
  localparam int NSTR  = 1 << STRM_W;
  localparam int SRC_W = STRM_W + SLOT_W;
  localparam int ENT_W = SRC_W + CTL_W;

  logic [1:0]              sync_q;
  logic                    rst_sync_n;
  logic [2:0]              bit_idx;
  logic [SLOT_W-1:0]       slot_idx;
  logic                    wr_bank;
  logic                    slot_last;
  logic [NSTR*BYTE_W-1:0]  rx_bytes;
  logic [NSTR*ENT_W-1:0]   cur_ent;
  logic [NSTR-1:0]         rd_bank;
  logic [NSTR*SRC_W-1:0]   rd_addr;
  logic [NSTR*BYTE_W-1:0]  rd_data;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_sync_n = sync_q[1];

  tsi_timing #(.SLOT_W(SLOT_W)) u_timing (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bit_idx   (bit_idx),
    .slot_idx  (slot_idx),
    .wr_bank   (wr_bank),
    .slot_last (slot_last)
  );

  tsi_rx #(.NSTR(NSTR), .BYTE_W(BYTE_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sp_bypass (sp_bypass),
    .ser_in    (in_ser),
    .par_in    (in_par),
    .byte_out  (rx_bytes)
  );

  tsi_dmem #(.STRM_W(STRM_W), .SLOT_W(SLOT_W), .BYTE_W(BYTE_W)) u_dmem (
    .clk      (clk),
    .we       (slot_last),
    .wr_bank  (wr_bank),
    .wr_slot  (slot_idx),
    .wr_bytes (rx_bytes),
    .rd_bank  (rd_bank),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data)
  );

  tsi_cmem #(.STRM_W(STRM_W), .SLOT_W(SLOT_W), .ENT_W(ENT_W)) u_cmem (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .we      (cfg_we),
    .waddr   (cfg_addr),
    .wdata   (cfg_data),
    .rd_slot (slot_idx),
    .rd_ent  (cur_ent)
  );

  for (genvar o = 0; o < NSTR; o++) begin : g_out
    tsi_tx #(.STRM_W(STRM_W), .SLOT_W(SLOT_W)) u_tx (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .load      (slot_last),
      .ps_bypass (ps_bypass),
      .ent       (cur_ent[o*ENT_W +: ENT_W]),
      .cur_slot  (slot_idx),
      .wr_bank   (wr_bank),
      .mem_byte  (rd_data[o*BYTE_W +: BYTE_W]),
      .rd_bank   (rd_bank[o]),
      .rd_addr   (rd_addr[o*SRC_W +: SRC_W]),
      .ser_out   (out_ser[o]),
      .drv_en    (out_en[o]),
      .par_out   (out_par[o*BYTE_W +: BYTE_W])
    );
    // strobe bit leaves the connection memory unregistered
    assign ctl_strobe[o] = cur_ent[o*ENT_W + ENT_W - 1];
  end
endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk #(
  parameter int NSTR   = 4,
  parameter int BYTE_W = 8
) (
  input logic                   clk,
  input logic                   rst_sync_n,
  input logic [2:0]             bit_idx,
  input logic                   ps_bypass,
  input logic                   cfg_we,
  input logic [NSTR-1:0]        out_ser,
  input logic [NSTR-1:0]        out_en,
  input logic [NSTR*BYTE_W-1:0] out_par,
  input logic [NSTR-1:0]        ctl_strobe
);
  p_idle_high_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    &(out_ser | out_en));

  p_bypass_quiet_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ps_bypass |-> &out_ser);

  p_par_idle_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ps_bypass |-> &out_par);

  p_en_steady_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bit_idx != 3'd0) |-> $stable(out_en));

  p_strobe_steady_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((bit_idx != 3'd0) && !$past(cfg_we)) |-> $stable(ctl_strobe));
endmodule

bind tsi_switch tsi_switch_chk #(.NSTR(NSTR), .BYTE_W(tsi_pkg::BYTE_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .bit_idx    (bit_idx),
  .ps_bypass  (ps_bypass),
  .cfg_we     (cfg_we),
  .out_ser    (out_ser),
  .out_en     (out_en),
  .out_par    (out_par),
  .ctl_strobe (ctl_strobe)
);

// File: tb/test_tsi_switch.sv
module test_tsi_switch;
  localparam int NSTR  = 4;
  localparam int NSLOT = 64;
  localparam int FRAME = NSLOT * 8;
  localparam int NF    = 6;
  localparam int RUN   = NF * FRAME + 16;

  logic              clk, rst_n, sp_bypass, ps_bypass, cfg_we;
  logic [NSTR-1:0]   in_ser;
  logic [NSTR*8-1:0] in_par;
  logic [7:0]        cfg_addr;
  logic [11:0]       cfg_data;
  logic [NSTR-1:0]   out_ser, out_en, ctl_strobe;
  logic [NSTR*8-1:0] out_par;

  int checks = 0;
  int errors = 0;
  bit run    = 0;

  typedef struct packed {
    logic [NSTR-1:0]   en;
    logic [NSTR*8-1:0] dat;
    logic [NSTR*4-1:0] req;
  } exp_t;
  exp_t q[$];

  tsi_switch i_tsi_switch (
    .clk(clk), .rst_n(rst_n), .sp_bypass(sp_bypass), .ps_bypass(ps_bypass),
    .in_ser(in_ser), .in_par(in_par), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .out_ser(out_ser), .out_en(out_en), .out_par(out_par),
    .ctl_strobe(ctl_strobe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] data_of(int f, int st, int sl);
    return 8'((f * 29 + st * 71 + sl * 13 + 5) % 256);
  endfunction

  // entry: [11] strobe, [10] pattern, [9] min delay, [8] enable, [7:6] stream, [5:0] slot
  function automatic logic [11:0] cfg_of(int o, int s);
    logic cs, pat, mn, en;
    logic [1:0] st;
    logic [5:0] k;
    logic [7:0] src;
    pat = 1'b0; mn = 1'b0; en = 1'b1; cs = 1'b0; st = 2'(o); k = 6'(s);
    case (o)
      0: begin st = 2'(s % 4); k = 6'(63 - s); cs = (s % 4 == 0); end
      1: begin
        mn = 1'b1; st = 2'((s + 1) % 4); cs = (s % 4 == 1);
        if (s % 8 == 0)      k = 6'(s);
        else if (s % 8 == 1) k = 6'(s - 1);
        else                 k = 6'((s * 7) % 64);
      end
      2: begin pat = 1'b1; cs = (s % 4 == 2); end
      default: begin en = (s % 2 == 1); st = 2'd3; k = 6'(s); cs = (s % 3 == 0); end
    endcase
    src = pat ? 8'((s * 11 + 7) % 256) : {st, k};
    return {cs, pat, mn, en, src};
  endfunction

  function automatic string req_name(int n);
    case (n)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // driver side: expected result of output slot s in frame f
  task automatic push_expected(int f, int s);
    exp_t it;
    it = '0;
    for (int o = 0; o < NSTR; o++) begin
      logic [11:0] e;
      logic [7:0]  b;
      int          sf, tag;
      e = cfg_of(o, s);
      sf = (e[9] && (int'(e[5:0]) < s)) ? f : f - 1;
      b  = e[10] ? e[7:0] : data_of(sf, int'(e[7:6]), int'(e[5:0]));
      if (!e[8])         tag = 6;
      else if (e[10])    tag = 5;
      else if (sf == 3)  tag = 8;
      else if (e[9])     tag = 4;
      else               tag = 3;
      it.en[o]          = e[8];
      it.dat[o*8 +: 8]  = b;
      it.req[o*4 +: 4]  = 4'(tag);
    end
    q.push_back(it);
  endtask

  // driver
  initial begin
    rst_n = 1'b0; sp_bypass = 1'b0; ps_bypass = 1'b0; cfg_we = 1'b0;
    in_ser = '0; in_par = '0; cfg_addr = '0; cfg_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    run = 1'b1;
    for (int c = 0; c < RUN; c++) begin
      int f, sl, b;
      @(negedge clk);
      #1;
      f  = c / FRAME;
      sl = (c / 8) % NSLOT;
      b  = c % 8;
      sp_bypass = (f == 3);
      ps_bypass = (f == 4);
      cfg_we    = (c < NSTR * NSLOT);
      cfg_addr  = 8'(c);
      cfg_data  = cfg_of(c / NSLOT, c % NSLOT);
      for (int st = 0; st < NSTR; st++) begin
        logic [7:0] d;
        d = data_of(f, st, sl);
        in_ser[st]        = sp_bypass ? ~d[7 - b] : d[7 - b];
        in_par[st*8 +: 8] = sp_bypass ? d : ~d;
      end
      if (b == 7 && f >= 1 && f < NF) push_expected(f, sl);
    end
  end

  // monitor
  initial begin
    exp_t cur;
    bit   act;
    act = 1'b0;
    cur = '0;
    wait (run);
    for (int c = 0; c < RUN; c++) begin
      int f, sl, b;
      @(negedge clk);
      f  = c / FRAME;
      sl = (c / 8) % NSLOT;
      b  = c % 8;
      if (c == 0) begin
        // R1: idle outputs after reset
        check(out_en == '0, "R1", "out_en", int'(out_en), 0);
        check(&out_ser, "R1", "out_ser", int'(out_ser), 'hF);
        check(ctl_strobe == '0, "R1", "ctl_strobe", int'(ctl_strobe), 0);
        check(&out_par, "R1", "out_par", int'(out_par), 'hFFFFFFFF);
      end
      if (b == 0) begin
        act = (q.size() > 0);
        if (act) cur = q.pop_front();
      end
      if (act) begin
        for (int o = 0; o < NSTR; o++) begin
          string rq;
          logic [7:0] eb;
          rq = req_name(int'(cur.req[o*4 +: 4]));
          eb = cur.dat[o*8 +: 8];
          // R2: enable held per slot, R6 when disabled
          check(out_en[o] == cur.en[o], cur.en[o] ? "R2" : "R6", "out_en",
                int'(out_en[o]), int'(cur.en[o]));
          if (ps_bypass) begin
            check(out_ser[o] == 1'b1, "R9", "out_ser in bypass", int'(out_ser[o]), 1);
            if (b == 4)
              check(out_par[o*8 +: 8] == (cur.en[o] ? eb : 8'hFF), rq == "R6" ? "R6" : "R9",
                    "out_par", int'(out_par[o*8 +: 8]), int'(cur.en[o] ? eb : 8'hFF));
          end else begin
            check(out_ser[o] == (cur.en[o] ? eb[7 - b] : 1'b1), rq, "out_ser bit",
                  int'(out_ser[o]), int'(cur.en[o] ? eb[7 - b] : 1'b1));
            if (b == 4)
              check(&out_par[o*8 +: 8], "R9", "out_par idle", int'(out_par[o*8 +: 8]), 'hFF);
          end
        end
      end
      if (f >= 1 && f < NF && b == 4) begin
        for (int o = 0; o < NSTR; o++) begin
          logic [11:0] e;
          e = cfg_of(o, sl);
          check(ctl_strobe[o] == e[11], "R7", "ctl_strobe", int'(ctl_strobe[o]), int'(e[11]));
        end
      end
    end
    check(q.size() == 0, "R2", "queue drained", q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule